// File: doc/BRIEF.md
# Frame Readout Sequencer

This block produces the readout timing for an image array of `NUM_LINES` lines. It divides the input clock by `CLK_DIV` to form a core-clock tick, and all sequencing advances on that tick. A frame begins with a frame overhead interval, during which the pixel charge is moved into pixel memory. The lines then follow one after another. Each line begins with a row overhead interval and then selects `NUM_KERNELS` groups of four pixels, one group per tick.

The outputs give the current phase (frame overhead, row overhead), the kernel and line numbers, a one-tick line-done pulse for an external line counter, and a frame-valid flag covering the whole readout. The block has no input from the integration logic and never stalls, so integration of the next frame can run while the current frame is read out. A start request is honoured only when the sequencer is idle.

Defaults: 480 lines, 160 kernels per line, a divide-by-4 core clock, and overhead durations given as parameters in core ticks.

Top module: `frame_readout_seq`

## Requirements
- R1: `core_tick` is high for one input-clock cycle in every `CLK_DIV`. The first pulse comes in the `CLK_DIV`-th cycle after reset is released. All other outputs change only at clock edges where `core_tick` is high.
- R2: During and after reset, every output is 0 until the first tick.
- R3: A `frame_start` seen high at a tick in idle enters frame overhead. For the next `FRAME_OVH_CYC` ticks `frame_ovh` is 1, `row_ovh` is 0, `kernel_idx` is 0 and `line_idx` is 0. With no start the block stays idle.
- R4: Every line opens with `ROW_OVH_CYC` ticks in which `row_ovh` is 1 and `kernel_idx` is 0.
- R5: After row overhead, `kernel_idx` takes the values 1 to `NUM_KERNELS`, one value per tick. Outside this phase it is 0.
- R6: `line_idx` holds the current line number, 1 to `NUM_LINES`, through that line's row overhead and kernels. It is 0 in idle and during frame overhead.
- R7: `line_done` is 1 for exactly one tick after the last kernel of each line. That tick is the next line's first row-overhead tick, or the first idle tick after the last line.
- R8: `frame_valid` is 1 from the first frame-overhead tick through the last kernel of the last line, and 0 in idle. `frame_ovh` and `row_ovh` are never 1 together.
- R9: `frame_start` has no effect while a frame is in progress, including at the tick that ends the frame. A start still held in the following idle tick begins a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_start | input | 1 | Frame start request, sampled at ticks |
| core_tick | output | 1 | Core-clock enable, one cycle in `CLK_DIV` |
| frame_ovh | output | 1 | Frame overhead phase |
| row_ovh | output | 1 | Row overhead phase |
| kernel_idx | output | $clog2(NUM_KERNELS+1) | Kernel number 1..NUM_KERNELS, 0 when none |
| line_idx | output | $clog2(NUM_LINES+1) | Line number 1..NUM_LINES, 0 when none |
| line_done | output | 1 | One-tick pulse after each line's last kernel |
| frame_valid | output | 1 | Readout in progress |

## Verification
Each result is due one tick after the tick that causes it. A start seen at tick n shows up as frame overhead right after tick n, and each phase step also lands right after its own tick. The bench locks onto `core_tick`: it waits for the falling clock edge with `core_tick` high, steps over the next rising edge, and samples one time unit later. This means every comparison falls on the first settled value after a tick. The bench also samples in the cycles between ticks, to show the outputs hold their values there.

// File: rtl/frame_readout_seq.sv
module frame_readout_seq #(
  parameter int NUM_LINES     = 480,
  parameter int NUM_KERNELS   = 160,
  parameter int FRAME_OVH_CYC = 8,
  parameter int ROW_OVH_CYC   = 4,
  parameter int CLK_DIV       = 4,
  localparam int LW = $clog2(NUM_LINES + 1),
  localparam int KW = $clog2(NUM_KERNELS + 1),
  localparam int DW = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1,
  localparam int OMAX = (FRAME_OVH_CYC > ROW_OVH_CYC) ? FRAME_OVH_CYC : ROW_OVH_CYC,
  localparam int CW = (OMAX > 2) ? $clog2(OMAX) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_start,
  output logic          core_tick,
  output logic          frame_ovh,
  output logic          row_ovh,
  output logic [KW-1:0] kernel_idx,
  output logic [LW-1:0] line_idx,
  output logic          line_done,
  output logic          frame_valid
);

  typedef enum logic [1:0] {S_IDLE, S_FOVH, S_ROVH, S_KERN} phase_t;

  phase_t        st;
  logic [DW-1:0] dcnt;
  logic [CW-1:0] ocnt;

  assign core_tick   = (dcnt == DW'(CLK_DIV - 1));
  assign frame_ovh   = (st == S_FOVH);
  assign row_ovh     = (st == S_ROVH);
  assign frame_valid = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt       <= '0;
      st         <= S_IDLE;
      ocnt       <= '0;
      kernel_idx <= '0;
      line_idx   <= '0;
      line_done  <= 1'b0;
    end else begin
      dcnt <= core_tick ? '0 : dcnt + DW'(1);
      if (core_tick) begin
        line_done <= 1'b0;
        case (st)
          S_IDLE: if (frame_start) begin
            st   <= S_FOVH;
            ocnt <= '0;
          end
          S_FOVH: begin
            if (ocnt == CW'(FRAME_OVH_CYC - 1)) begin
              st       <= S_ROVH;
              ocnt     <= '0;
              line_idx <= LW'(1);
            end else ocnt <= ocnt + CW'(1);
          end
          S_ROVH: begin
            if (ocnt == CW'(ROW_OVH_CYC - 1)) begin
              st         <= S_KERN;
              kernel_idx <= KW'(1);
            end else ocnt <= ocnt + CW'(1);
          end
          S_KERN: begin
            if (kernel_idx == KW'(NUM_KERNELS)) begin
              line_done  <= 1'b1;
              kernel_idx <= '0;
              ocnt       <= '0;
              if (line_idx == LW'(NUM_LINES)) begin
                st       <= S_IDLE;
                line_idx <= '0;
              end else begin
                st       <= S_ROVH;
                line_idx <= line_idx + LW'(1);
              end
            end else kernel_idx <= kernel_idx + KW'(1);
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/frame_readout_seq_chk.sv
module frame_readout_seq_chk #(
  parameter int NUM_LINES   = 480,
  parameter int NUM_KERNELS = 160,
  localparam int LW = $clog2(NUM_LINES + 1),
  localparam int KW = $clog2(NUM_KERNELS + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          core_tick,
  input logic          frame_ovh,
  input logic          row_ovh,
  input logic [KW-1:0] kernel_idx,
  input logic [LW-1:0] line_idx,
  input logic          line_done,
  input logic          frame_valid
);

  assert_tick_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    core_tick |=> !core_tick);

  assert_hold_between_ticks_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !core_tick |=> ($stable(kernel_idx) && $stable(line_idx) && $stable(line_done) && $stable(frame_valid)));

  assert_frame_opens_ovh_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_valid) |-> (frame_ovh && line_idx == '0));

  assert_kernel_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    kernel_idx <= KW'(NUM_KERNELS));

  assert_kernel_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (core_tick && kernel_idx != '0 && kernel_idx < KW'(NUM_KERNELS))
      |=> (kernel_idx == $past(kernel_idx) + KW'(1)));

  assert_line_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    line_idx <= LW'(NUM_LINES));

  assert_done_place_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_done) |-> ((row_ovh || !frame_valid) && kernel_idx == '0));

  assert_ovh_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_ovh && row_ovh));

endmodule

bind frame_readout_seq frame_readout_seq_chk #(
  .NUM_LINES(NUM_LINES),
  .NUM_KERNELS(NUM_KERNELS)
) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .core_tick(core_tick),
  .frame_ovh(frame_ovh),
  .row_ovh(row_ovh),
  .kernel_idx(kernel_idx),
  .line_idx(line_idx),
  .line_done(line_done),
  .frame_valid(frame_valid)
);

// File: tb/frame_readout_seq_bench.sv
module frame_readout_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NL  = 4;
  localparam int NK  = 5;
  localparam int FOV = 3;
  localparam int ROV = 2;
  localparam int DIV = 4;
  localparam int LW = $clog2(NL + 1);
  localparam int KW = $clog2(NK + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          frame_start = 1'b0;
  logic          core_tick, frame_ovh, row_ovh, line_done, frame_valid;
  logic [KW-1:0] kernel_idx;
  logic [LW-1:0] line_idx;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_readout_seq #(
    .NUM_LINES(NL), .NUM_KERNELS(NK), .FRAME_OVH_CYC(FOV),
    .ROW_OVH_CYC(ROV), .CLK_DIV(DIV)
  ) u_frame_readout_seq (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .core_tick(core_tick),
    .frame_ovh(frame_ovh), .row_ovh(row_ovh), .kernel_idx(kernel_idx),
    .line_idx(line_idx), .line_done(line_done), .frame_valid(frame_valid)
  );

  task automatic cmp(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic tick();
    do @(negedge clk); while (!core_tick);
    @(posedge clk);
    #1;
  endtask

  task automatic expect_all(input int fo, input int ro, input int k, input int l,
                            input int ld, input int fv);
    cmp("R3", "frame_ovh", int'(frame_ovh), fo);
    cmp("R4", "row_ovh", int'(row_ovh), ro);
    cmp("R5", "kernel_idx", int'(kernel_idx), k);
    cmp("R6", "line_idx", int'(line_idx), l);
    cmp("R7", "line_done", int'(line_done), ld);
    cmp("R8", "frame_valid", int'(frame_valid), fv);
  endtask

  // Called while observing the first frame-overhead tick; ends on the idle tick after the frame.
  task automatic walk_frame();
    for (int f = 0; f < FOV; f++) begin
      expect_all(1, 0, 0, 0, 0, 1);
      tick();
    end
    for (int l = 1; l <= NL; l++) begin
      for (int r = 0; r < ROV; r++) begin
        expect_all(0, 1, 0, l, (r == 0 && l > 1) ? 1 : 0, 1);
        tick();
      end
      for (int k = 1; k <= NK; k++) begin
        expect_all(0, 0, k, l, 0, 1);
        tick();
      end
    end
    expect_all(0, 0, 0, 0, 1, 0);
  endtask

  task automatic test_reset();
    cmp("R2", "core_tick", int'(core_tick), 0);
    cmp("R2", "frame_valid", int'(frame_valid), 0);
    cmp("R2", "kernel_idx", int'(kernel_idx), 0);
    cmp("R2", "line_idx", int'(line_idx), 0);
    cmp("R2", "line_done", int'(line_done), 0);
    cmp("R2", "phases", int'(frame_ovh) + int'(row_ovh), 0);
  endtask

  task automatic test_tick_period();
    int n;
    @(negedge clk); rst_n = 1'b1;
    n = 0;
    do begin @(posedge clk); #1; n++; end while (!core_tick);
    cmp("R1", "first tick delay", n, DIV - 1);
    for (int i = 0; i < 3; i++) begin
      n = 0;
      do begin @(posedge clk); #1; n++; end while (!core_tick);
      cmp("R1", "tick period", n, DIV);
    end
  endtask

  task automatic test_idle_hold();
    for (int i = 0; i < 3; i++) begin
      tick();
      expect_all(0, 0, 0, 0, 0, 0);
    end
  endtask

  task automatic test_single_frame();
    frame_start = 1'b1;
    tick();
    frame_start = 1'b0;
    walk_frame();
    tick();
    expect_all(0, 0, 0, 0, 0, 0);
  endtask

  task automatic test_hold_between_ticks();
    logic [KW-1:0] k0;
    frame_start = 1'b1;
    tick();
    frame_start = 1'b0;
    for (int i = 0; i < FOV + ROV; i++) tick();
    k0 = kernel_idx;
    cmp("R5", "first kernel", int'(k0), 1);
    for (int c = 0; c < DIV - 1; c++) begin
      @(posedge clk); #1;
      cmp("R1", "kernel held between ticks", int'(kernel_idx), int'(k0));
    end
    while (frame_valid) tick();
  endtask

  task automatic test_start_ignored();
    frame_start = 1'b1;
    tick();
    walk_frame();
    tick();
    cmp("R9", "restart frame_ovh", int'(frame_ovh), 1);
    cmp("R9", "restart frame_valid", int'(frame_valid), 1);
    frame_start = 1'b0;
    walk_frame();
    tick();
    expect_all(0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 3 + 2);
    test_reset();
    test_tick_period();
    test_idle_hold();
    test_single_frame();
    test_hold_between_ticks();
    test_start_ignored();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule